// File: doc/BRIEF.md
# Instruction Opcode Membership Checker

This block sits between instruction fetch and decode and screens each fetched instruction for corruption before it executes. Software loads a bitmap with one bit per possible opcode value, where a set bit means that the opcode occurs in the program about to run. For every valid fetched word, the block uses only the opcode field as an index into the bitmap. It flags an error in the same cycle if the indexed bit is clear, so downstream logic can suppress issue.

The check is deliberately approximate. A word that is corrupted into another opcode the program also uses passes silently. A word taken from the program itself is never flagged. The whole check costs one bitmap register and a single bit read, with no hashing. A sticky status bit records the first detected error and holds the offending word until software clears it. Checking stays off until software arms it, and any rewrite of the bitmap turns it off again.

Top module: `opcode_guard`

## Requirements
- R1: After reset, `check_armed`, `err_sticky` and `err_insn` are all zero, and `insn_err` is low.
- R2: The opcode is `insn_data[15:10]` and selects bitmap bit `opcode`. Config word k (address k, k = 0 or 1) holds bitmap bits 32k+31 down to 32k. `insn_err` rises in the same cycle as `insn_valid` exactly when checking is armed and the selected bit is 0.
- R3: An instruction whose opcode bit is 1 never raises `insn_err`.
- R4: While checking is disarmed, `insn_err` stays low for every instruction.
- R5: A write to address 2 sets the arm state to `cfg_wdata[0]` from the next cycle. A write to address 0 or 1 updates that bitmap word and disarms checking from the next cycle.
- R6: The first error taken while `err_sticky` is low sets `err_sticky` and loads `err_insn` with the offending word on the next cycle. Later errors change neither.
- R7: Any write to address 3 clears `err_sticky` and `err_insn` on the next cycle. The clear wins over an error in the same cycle.
- R8: `out_valid` and `out_insn` equal `insn_valid` and `insn_data` in the same cycle.
- R9: With `insn_valid` low, `insn_err` stays low and the sticky status does not change.
- R10: Bits outside the opcode field have no effect on `insn_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0/1 bitmap words, 2 arm control, 3 status clear |
| cfg_wdata | input | 32 | Configuration write data |
| insn_valid | input | 1 | Fetched instruction valid |
| insn_data | input | 16 | Fetched instruction word |
| out_valid | output | 1 | Pass-through valid |
| out_insn | output | 16 | Pass-through instruction |
| insn_err | output | 1 | Opcode not in the loaded set (combinational) |
| check_armed | output | 1 | Checking enabled |
| err_sticky | output | 1 | Error seen since the last clear |
| err_insn | output | 16 | First offending instruction word |

## Verification
A wrong bitmap bit shows up at the ports in the same cycle that an instruction with that opcode is presented. It appears either as a false error on a program opcode or as a missed error on a flipped one. A wrong arm state or a broken bitmap word mapping shows up the same way on the next instruction. A wrong sticky state or a wrong captured word becomes visible one cycle after the error or the clear, and it persists until the next clear.

// File: rtl/opcode_guard.sv
module opcode_guard #(
  parameter int INSN_W  = 16,
  parameter int OPC_LSB = 10,
  parameter int OPC_W   = 6,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_data,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_insn,
  output logic              insn_err,
  output logic              check_armed,
  output logic              err_sticky,
  output logic [INSN_W-1:0] err_insn
);
  localparam int VEC_BITS  = 1 << OPC_W;
  localparam int NUM_WORDS = VEC_BITS / WORD_W;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ARM_ADDR = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_WORDS + 1);

  logic [VEC_BITS-1:0] opc_map;
  logic [OPC_W-1:0]    opcode;
  logic                vec_wr, arm_wr, clr_wr;

  assign opcode    = insn_data[OPC_LSB +: OPC_W];
  assign vec_wr    = cfg_we && (cfg_addr < ARM_ADDR);
  assign arm_wr    = cfg_we && (cfg_addr == ARM_ADDR);
  assign clr_wr    = cfg_we && (cfg_addr == CLR_ADDR);

  assign out_valid = insn_valid;
  assign out_insn  = insn_data;
  assign insn_err  = insn_valid && check_armed && !opc_map[opcode];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_map <= '0;
    end else if (vec_wr) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (cfg_addr == ADDR_W'(w)) opc_map[w*WORD_W +: WORD_W] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      check_armed <= 1'b0;
    else if (vec_wr) check_armed <= 1'b0;
    else if (arm_wr) check_armed <= cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      err_insn   <= '0;
    end else if (clr_wr) begin
      err_sticky <= 1'b0;
      err_insn   <= '0;
    end else if (insn_err && !err_sticky) begin
      err_sticky <= 1'b1;
      err_insn   <= insn_data;
    end
  end
endmodule

// File: rtl/opcode_guard_chk.sv
module opcode_guard_chk #(
  parameter int INSN_W    = 16,
  parameter int NUM_WORDS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic              insn_valid,
  input logic [INSN_W-1:0] insn_data,
  input logic              insn_err,
  input logic              check_armed,
  input logic              err_sticky,
  input logic [INSN_W-1:0] err_insn
);
  logic clr_w, vec_w;
  assign clr_w = cfg_we && (cfg_addr == 2'(NUM_WORDS + 1));
  assign vec_w = cfg_we && (cfg_addr < 2'(NUM_WORDS));

  // R2
  err_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_err |-> (insn_valid && check_armed));
  // R5
  vec_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_w |=> !check_armed);
  // R6
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_err && !err_sticky && !clr_w) |=> (err_sticky && err_insn == $past(insn_data)));
  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr_w) |=> (err_sticky && $stable(err_insn)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (!err_sticky && err_insn == '0));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid && !clr_w) |=> $stable(err_sticky));
endmodule

bind opcode_guard opcode_guard_chk #(.INSN_W(INSN_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .insn_valid(insn_valid), .insn_data(insn_data), .insn_err(insn_err),
  .check_armed(check_armed), .err_sticky(err_sticky), .err_insn(err_insn)
);

// File: tb/test_opcode_guard.sv
module test_opcode_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_data = '0;
  logic        out_valid, insn_err, check_armed, err_sticky;
  logic [15:0] out_insn, err_insn;

  int checks = 0;
  int errors = 0;
  logic [63:0] model;
  logic [5:0]  legal [6] = '{6'h00, 6'h05, 6'h07, 6'h12, 6'h21, 6'h3F};
  logic [15:0] first_bad;
  logic        have_bad;

  always #5 clk = ~clk;

  opcode_guard i_opcode_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .insn_valid(insn_valid), .insn_data(insn_data),
    .out_valid(out_valid), .out_insn(out_insn), .insn_err(insn_err),
    .check_armed(check_armed), .err_sticky(err_sticky), .err_insn(err_insn)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic present(logic [15:0] w, logic exp_err, string req);
    @(negedge clk);
    insn_valid = 1'b1; insn_data = w;
    #1;
    chk(req, insn_err, exp_err);
    chk("R8", {out_valid, out_insn}, {1'b1, w});
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1", {check_armed, err_sticky, err_insn}, '0);
    present({6'h01, 10'h000}, 1'b0, "R1");
  endtask

  task automatic t_load;
    model = '0;
    foreach (legal[i]) model[legal[i]] = 1'b1;
    cfg_write(2'd0, model[31:0]);
    cfg_write(2'd1, model[63:32]);
    #1 chk("R5", check_armed, 1'b0);
    present({6'h02, 10'h155}, 1'b0, "R4");
    cfg_write(2'd2, 32'h1);
    #1 chk("R5", check_armed, 1'b1);
  endtask

  task automatic t_legal;
    foreach (legal[i]) begin
      present({legal[i], 10'h000}, 1'b0, "R3");
      present({legal[i], 10'h3FF}, 1'b0, "R10");
    end
    chk("R9", err_sticky, 1'b0);
  endtask

  task automatic t_flips;
    have_bad = 1'b0;
    foreach (legal[i]) begin
      for (int b = 0; b < 6; b++) begin
        logic [5:0] op;
        op = legal[i] ^ (6'd1 << b);
        present({op, 10'h2A5}, ~model[op], "R2");
        if (!model[op] && !have_bad) begin
          have_bad = 1'b1;
          first_bad = {op, 10'h2A5};
        end
      end
    end
    chk("R6", {err_sticky, err_insn}, {have_bad, first_bad});
  endtask

  task automatic t_idle;
    @(negedge clk);
    insn_valid = 1'b0; insn_data = {6'h02, 10'h000};
    #1 chk("R9", insn_err, 1'b0);
    @(negedge clk);
    chk("R9", {err_sticky, err_insn}, {1'b1, first_bad});
  endtask

  task automatic t_clear;
    cfg_write(2'd3, 32'h0);
    chk("R7", {err_sticky, err_insn}, '0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd3;
    insn_valid = 1'b1; insn_data = {6'h02, 10'h001};
    @(negedge clk);
    cfg_we = 1'b0; insn_valid = 1'b0;
    chk("R7", err_sticky, 1'b0);
    present({6'h03, 10'h00F}, 1'b1, "R2");
    chk("R6", {err_sticky, err_insn}, {1'b1, 6'h03, 10'h00F});
  endtask

  task automatic t_disarm;
    cfg_write(2'd1, 32'hFFFF_FFFF);
    #1 chk("R5", check_armed, 1'b0);
    present({6'h02, 10'h000}, 1'b0, "R4");
    cfg_write(2'd2, 32'h1);
    present({6'h30, 10'h000}, 1'b0, "R2");
    present({6'h02, 10'h000}, 1'b1, "R2");
    cfg_write(2'd2, 32'h0);
    #1 chk("R5", check_armed, 1'b0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_legal();
    t_flips();
    t_idle();
    t_clear();
    t_disarm();
    finish_run();
  end
endmodule